// File: doc/BRIEF.md
# Matrix Row/Column Index Selector

This block builds an output matrix from chosen rows or columns of one M-by-N input matrix per sample. In index mode a vector of L signed indices picks, in slot order, which row (row mode) or column (column mode) of the input lands in each output slot. The same input row or column may appear in several slots or in none. The index vector comes from the `idx_i` port or from a bank of L writable index registers. Indices are read as zero-based or one-based under a configuration bit. Out-of-range values are clamped to the nearest valid row or column, and a policy input chooses whether such a clamp passes silently, raises a per-sample warning, or sets a sticky error flag.

In logical mode a bit mask replaces the index vector. Every set mask bit selects the matching row or column. The selected items are packed in ascending order from slot 0. The remaining slots, up to the number of items in the selected dimension, are filled with a programmable fill word. Optional input and output register stages set the latency, and the valid strobe follows the data through them.

Top module: `rc_index_select`

## Requirements
- R1: Row mode (`sel_cols_i`=0). Output slot k holds input row p(k), where p(k) is the clamped position of index k. Element c of that row sits in slot k at `dat_o[(k*MAXD+c)*W_DATA +: W_DATA]`, where MAXD = max(M,N). The input element (r,c) is at `mat_i[(r*N+c)*W_DATA +: W_DATA]`. Index k is at `idx_i[k*W_IDX +: W_IDX]` in two's complement. Every output element not written is zero.
- R2: Column mode (`sel_cols_i`=1). Output slot k holds input column p(k), and element r of that column sits in slot k at element position r.
- R3: Any row or column may be selected by several slots or by none. Each slot is resolved independently.
- R4: With `zero_base_i`=1, index 0 selects the first row or column. With `zero_base_i`=0, index 1 selects it.
- R5: A position at or beyond the size of the selected dimension clamps to the last row or column. For example, one-based index 30 selects row M in row mode and column N in column mode.
- R6: A negative position clamps to the first row or column. For example, one-based index -2 and zero-based index -1 both select position 0.
- R7: `policy_i` encoding: 0 is silent, 1 is warn, 2 is error, and 3 acts as silent. Under warn, `warn_o` is high with the output sample whenever any index of that sample was clamped. Under error, such a sample sets `err_o`, which stays high until reset, and `warn_o` stays low. The data is the clamped result under every policy.
- R8: With `logical_i`=1, mask bit d (d below D, the size of the selected dimension) selects item d. Selected items fill slots 0 upward in ascending d. Slots from the count of selected items up to D-1 carry `fill_i` in every element of the item length. Slots at D and above, and mask bits at D and above, are zero or ignored. Logical mode never warns or errors.
- R9: With `idx_src_i`=1, the index vector is taken from the register bank instead of `idx_i`. A write with `idx_we_i` stores `idx_wdata_i` into entry `idx_waddr_i`. Samples presented in any later cycle use the new value.
- R10: A sample presented with `vld_i` appears with `vld_o` exactly IN_REGS+OUT_REGS cycles later, and `vld_o` is low otherwise.
- R11: After reset, `vld_o`, `warn_o` and `err_o` are low and the register bank holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Input sample valid |
| mat_i | input | M*N*W_DATA | Input matrix, row-major |
| sel_cols_i | input | 1 | 0 selects rows, 1 selects columns |
| zero_base_i | input | 1 | 1 zero-based indices, 0 one-based |
| logical_i | input | 1 | 1 selects mask mode |
| policy_i | input | 2 | Out-of-range policy |
| idx_src_i | input | 1 | 1 takes indices from the register bank |
| idx_i | input | L*W_IDX | Per-sample index vector |
| mask_i | input | MAXD | Selection mask for logical mode |
| fill_i | input | W_DATA | Fill word for logical mode |
| idx_we_i | input | 1 | Register bank write enable |
| idx_waddr_i | input | AW | Register bank entry |
| idx_wdata_i | input | W_IDX | Register bank write data |
| vld_o | output | 1 | Output sample valid |
| dat_o | output | NSLOT*MAXD*W_DATA | Output slots, NSLOT = max(L,MAXD) |
| warn_o | output | 1 | Clamp warning for this output sample |
| err_o | output | 1 | Sticky clamp error |

## Verification
Several properties are checked on every cycle by assertions. Each clamped slot position stays below the size of the selected dimension. The valid strobe tracks the input stage through the output register. The error flag never falls without reset. A warning only comes with a valid sample, and a logical-mode sample never warns. The bench scenarios are needed for the parts the assertions cannot see: that the right row or column lands in each slot, the boundary values that clamp, the base offset, the order of packing and the fill under different masks, and that bank writes reach later samples.

// File: rtl/rcsel_pkg.sv
package rcsel_pkg;

    typedef enum logic [1:0] {
        POL_SILENT = 2'b00,
        POL_WARN   = 2'b01,
        POL_ERROR  = 2'b10,
        POL_RSVD   = 2'b11
    } policy_e;

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rcsel_clamp.sv
module rcsel_clamp #(
    parameter int W_IDX = 6,
    parameter int PW    = 3
) (
    input  logic signed [W_IDX-1:0] idx_i,
    input  logic                    zero_base_i,
    input  logic [PW:0]             dim_i,
    output logic [PW-1:0]           pos_o,
    output logic                    oor_o
);
    localparam int W_EXT = ((W_IDX > PW + 1) ? W_IDX : PW + 1) + 2;

    logic signed [W_EXT-1:0] idx_x;
    logic signed [W_EXT-1:0] base_x;
    logic signed [W_EXT-1:0] dim_x;
    logic signed [W_EXT-1:0] adj;
    logic                    lo;
    logic                    hi;

    always_comb begin
        idx_x  = W_EXT'(idx_i);
        base_x = zero_base_i ? '0 : W_EXT'(1);
        dim_x  = $signed(W_EXT'(dim_i));
        adj    = idx_x - base_x;
        lo     = adj < 0;
        hi     = adj >= dim_x;
        if (lo) begin
            pos_o = '0;
        end else if (hi) begin
            pos_o = PW'(dim_i - (PW+1)'(1));
        end else begin
            pos_o = adj[PW-1:0];
        end
        oor_o = lo | hi;
    end

endmodule

// File: rtl/rcsel_gather.sv
module rcsel_gather #(
    parameter int M     = 4,
    parameter int N     = 5,
    parameter int L     = 3,
    parameter int W     = 8,
    parameter int MAXD  = 5,
    parameter int NSLOT = 5,
    parameter int PW    = 3,
    parameter int CW    = 3
) (
    input  logic [M*N*W-1:0]        mat_i,
    input  logic [L*PW-1:0]         pos_i,
    input  logic                    sel_cols_i,
    input  logic                    logical_i,
    input  logic [MAXD-1:0]         mask_i,
    input  logic [W-1:0]            fill_i,
    output logic [NSLOT*MAXD*W-1:0] dat_o
);
    logic [CW-1:0]    dcount;
    logic [CW-1:0]    ilen;
    logic [CW-1:0]    pre [MAXD+1];
    logic [PW-1:0]    spos [NSLOT];
    logic [NSLOT-1:0] son;
    logic [NSLOT-1:0] sfill;

    // slot plan: which item each slot takes, or whether it is filled
    always_comb begin
        dcount = sel_cols_i ? CW'(N) : CW'(M);
        ilen   = sel_cols_i ? CW'(M) : CW'(N);
        pre[0] = '0;
        for (int d = 0; d < MAXD; d++) begin
            pre[d+1] = pre[d] + CW'(mask_i[d] && (CW'(d) < dcount));
        end
        for (int s = 0; s < NSLOT; s++) begin
            spos[s]  = '0;
            son[s]   = 1'b0;
            sfill[s] = 1'b0;
        end
        if (logical_i) begin
            for (int s = 0; s < NSLOT; s++) begin
                for (int d = 0; d < MAXD; d++) begin
                    if (mask_i[d] && (CW'(d) < dcount) && (pre[d] == CW'(s))) begin
                        spos[s] = PW'(d);
                        son[s]  = 1'b1;
                    end
                end
                sfill[s] = !son[s] && (CW'(s) < dcount);
            end
        end else begin
            for (int s = 0; s < L; s++) begin
                spos[s] = pos_i[s*PW +: PW];
                son[s]  = 1'b1;
            end
        end
    end

    // compare-and-select gather into slot-major output
    always_comb begin
        dat_o = '0;
        for (int s = 0; s < NSLOT; s++) begin
            for (int r = 0; r < M; r++) begin
                for (int c = 0; c < N; c++) begin
                    if (son[s] && !sel_cols_i && (spos[s] == PW'(r))) begin
                        dat_o[(s*MAXD+c)*W +: W] = mat_i[(r*N+c)*W +: W];
                    end
                    if (son[s] && sel_cols_i && (spos[s] == PW'(c))) begin
                        dat_o[(s*MAXD+r)*W +: W] = mat_i[(r*N+c)*W +: W];
                    end
                end
            end
            for (int e = 0; e < MAXD; e++) begin
                if (sfill[s] && (CW'(e) < ilen)) begin
                    dat_o[(s*MAXD+e)*W +: W] = fill_i;
                end
            end
        end
    end

endmodule

// File: rtl/rc_index_select.sv
module rc_index_select
    import rcsel_pkg::*;
#(
    parameter int M        = 4,
    parameter int N        = 5,
    parameter int L        = 3,
    parameter int W_DATA   = 8,
    parameter int W_IDX    = 6,
    parameter int IN_REGS  = 1,
    parameter int OUT_REGS = 1,
    localparam int MAXD    = max2(M, N),
    localparam int NSLOT   = max2(L, MAXD),
    localparam int PW      = $clog2(MAXD),
    localparam int CW      = $clog2(NSLOT + 1),
    localparam int AW      = (L > 1) ? $clog2(L) : 1,
    localparam int OUT_W   = NSLOT * MAXD * W_DATA
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_i,
    input  logic [M*N*W_DATA-1:0]   mat_i,
    input  logic                    sel_cols_i,
    input  logic                    zero_base_i,
    input  logic                    logical_i,
    input  logic [1:0]              policy_i,
    input  logic                    idx_src_i,
    input  logic [L*W_IDX-1:0]      idx_i,
    input  logic [MAXD-1:0]         mask_i,
    input  logic [W_DATA-1:0]       fill_i,
    input  logic                    idx_we_i,
    input  logic [AW-1:0]           idx_waddr_i,
    input  logic [W_IDX-1:0]        idx_wdata_i,
    output logic                    vld_o,
    output logic [OUT_W-1:0]        dat_o,
    output logic                    warn_o,
    output logic                    err_o
);
    typedef struct packed {
        logic                  vld;
        logic [M*N*W_DATA-1:0] mat;
        logic [L*W_IDX-1:0]    idx;
        logic                  cols;
        logic                  zb;
        logic                  logical;
        logic [1:0]            pol;
        logic [MAXD-1:0]       mask;
        logic [W_DATA-1:0]     fill;
    } smp_t;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] dat;
        logic             warn;
        logic             errhit;
        logic             logical;
    } res_t;

    typedef struct packed {
        logic [L*W_IDX-1:0] bank;
        logic               err;
    } st_t;

    st_t                st_d, st_q;
    smp_t               smp_now, a;
    res_t               res_now, b;
    logic [PW:0]        dim;
    logic [L*PW-1:0]    pos;
    logic [L-1:0]       oor;
    logic [OUT_W-1:0]   gat;
    logic               hit;

    // ---------------- index bank and sticky error ----------------
    always_comb begin
        st_d = st_q;
        for (int l = 0; l < L; l++) begin
            if (idx_we_i && (idx_waddr_i == AW'(l))) begin
                st_d.bank[l*W_IDX +: W_IDX] = idx_wdata_i;
            end
        end
        st_d.err = err_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- input capture ----------------
    always_comb begin
        smp_now.vld     = vld_i;
        smp_now.mat     = mat_i;
        smp_now.idx     = idx_src_i ? st_q.bank : idx_i;
        smp_now.cols    = sel_cols_i;
        smp_now.zb      = zero_base_i;
        smp_now.logical = logical_i;
        smp_now.pol     = policy_i;
        smp_now.mask    = mask_i;
        smp_now.fill    = fill_i;
    end

    if (IN_REGS != 0) begin : g_in_reg
        smp_t a_d, a_q;
        always_comb a_d = smp_now;
        always_ff @(posedge clk) begin
            if (rst) begin
                a_q <= '0;
            end else begin
                a_q <= a_d;
            end
        end
        assign a = a_q;
    end else begin : g_in_wire
        assign a = smp_now;
    end

    // ---------------- per-slot clamping ----------------
    assign dim = a.cols ? (PW+1)'(N) : (PW+1)'(M);

    for (genvar l = 0; l < L; l++) begin : g_clamp
        rcsel_clamp #(
            .W_IDX (W_IDX),
            .PW    (PW)
        ) u_clamp (
            .idx_i       (a.idx[l*W_IDX +: W_IDX]),
            .zero_base_i (a.zb),
            .dim_i       (dim),
            .pos_o       (pos[l*PW +: PW]),
            .oor_o       (oor[l])
        );

        AST_SLOT_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
            (a.vld && !a.logical) |-> ({1'b0, pos[l*PW +: PW]} < dim)); // R5
    end

    // ---------------- gather ----------------
    rcsel_gather #(
        .M     (M),
        .N     (N),
        .L     (L),
        .W     (W_DATA),
        .MAXD  (MAXD),
        .NSLOT (NSLOT),
        .PW    (PW),
        .CW    (CW)
    ) u_gather (
        .mat_i      (a.mat),
        .pos_i      (pos),
        .sel_cols_i (a.cols),
        .logical_i  (a.logical),
        .mask_i     (a.mask),
        .fill_i     (a.fill),
        .dat_o      (gat)
    );

    always_comb begin
        hit             = a.vld && !a.logical && (|oor);
        res_now.vld     = a.vld;
        res_now.dat     = gat;
        res_now.warn    = hit && (policy_e'(a.pol) == POL_WARN);
        res_now.errhit  = hit && (policy_e'(a.pol) == POL_ERROR);
        res_now.logical = a.logical;
    end

    // ---------------- output stage ----------------
    if (OUT_REGS != 0) begin : g_out_reg
        res_t b_d, b_q;
        always_comb b_d = res_now;
        always_ff @(posedge clk) begin
            if (rst) begin
                b_q <= '0;
            end else begin
                b_q <= b_d;
            end
        end
        assign b = b_q;

        AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            a.vld |=> vld_o); // R10
        AST_VLD_QUIET: assert property (@(posedge clk) disable iff (rst)
            !a.vld |=> !vld_o); // R10
    end else begin : g_out_wire
        assign b = res_now;
    end

    assign vld_o  = b.vld;
    assign dat_o  = b.dat;
    assign warn_o = b.warn;
    assign err_o  = st_q.err | b.errhit;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o); // R7
    AST_WARN_WITH_BEAT: assert property (@(posedge clk) disable iff (rst)
        warn_o |-> vld_o); // R7
    AST_LOGICAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (vld_o && b.logical) |-> !(warn_o || b.errhit)); // R8

endmodule

// File: tb/rc_index_select_tb.sv
module rc_index_select_tb;
    localparam int M     = 4;
    localparam int N     = 5;
    localparam int L     = 3;
    localparam int W     = 8;
    localparam int WI    = 6;
    localparam int INR   = 1;
    localparam int OUTR  = 1;
    localparam int LAT   = INR + OUTR;
    localparam int MAXD  = 5;
    localparam int NSLOT = 5;
    localparam int AW    = 2;
    localparam int OUT_W = NSLOT * MAXD * W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             vld = 1'b0;
    logic [M*N*W-1:0] mat = '0;
    logic             cols = 1'b0, zb = 1'b0, lg = 1'b0, src = 1'b0;
    logic [1:0]       pol = 2'd0;
    logic [L*WI-1:0]  idx = '0;
    logic [MAXD-1:0]  mask = '0;
    logic [W-1:0]     fill = '0;
    logic             we = 1'b0;
    logic [AW-1:0]    waddr = '0;
    logic [WI-1:0]    wdata = '0;
    logic             vld_o, warn_o, err_o;
    logic [OUT_W-1:0] dat_o;

    logic [L*WI-1:0]  bank_m = '0;
    logic             err_exp = 1'b0;
    int               n_chk = 0;
    int               n_fail = 0;
    bit               done = 1'b0;

    always #5 clk = ~clk;

    rc_index_select #(
        .M(M), .N(N), .L(L), .W_DATA(W), .W_IDX(WI), .IN_REGS(INR), .OUT_REGS(OUTR)
    ) u_dut (
        .clk(clk), .rst(rst), .vld_i(vld), .mat_i(mat), .sel_cols_i(cols),
        .zero_base_i(zb), .logical_i(lg), .policy_i(pol), .idx_src_i(src),
        .idx_i(idx), .mask_i(mask), .fill_i(fill), .idx_we_i(we),
        .idx_waddr_i(waddr), .idx_wdata_i(wdata), .vld_o(vld_o), .dat_o(dat_o),
        .warn_o(warn_o), .err_o(err_o)
    );

    task automatic chk(bit ok, string tag, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] item(int i, int e);
        return cols ? mat[(e*N+i)*W +: W] : mat[(i*N+e)*W +: W];
    endfunction

    function automatic int clamp_pos(int k);
        logic [L*WI-1:0] v = src ? bank_m : idx;
        int d = cols ? N : M;
        int p = int'($signed(v[k*WI +: WI])) - (zb ? 0 : 1);
        if (p < 0) p = 0;
        if (p > d - 1) p = d - 1;
        return p;
    endfunction

    function automatic bit any_oor();
        logic [L*WI-1:0] v = src ? bank_m : idx;
        int d = cols ? N : M;
        bit o = 1'b0;
        for (int k = 0; k < L; k++) begin
            int p = int'($signed(v[k*WI +: WI])) - (zb ? 0 : 1);
            if (p < 0 || p > d - 1) o = 1'b1;
        end
        return o && !lg;
    endfunction

    function automatic logic [OUT_W-1:0] ref_out();
        logic [OUT_W-1:0] r = '0;
        int d    = cols ? N : M;
        int elen = cols ? M : N;
        if (lg) begin
            int k = 0;
            for (int i = 0; i < d; i++) begin
                if (mask[i]) begin
                    for (int e = 0; e < elen; e++) r[(k*MAXD+e)*W +: W] = item(i, e);
                    k++;
                end
            end
            for (int s = k; s < d; s++)
                for (int e = 0; e < elen; e++) r[(s*MAXD+e)*W +: W] = fill;
        end else begin
            for (int s = 0; s < L; s++) begin
                int p = clamp_pos(s);
                for (int e = 0; e < elen; e++) r[(s*MAXD+e)*W +: W] = item(p, e);
            end
        end
        return r;
    endfunction

    task automatic put_idx(int a0, int a1, int a2);
        idx = {WI'(a2), WI'(a1), WI'(a0)};
    endtask

    task automatic rand_mat();
        for (int i = 0; i < M*N; i++) mat[i*W +: W] = W'($urandom);
    endtask

    task automatic wr_bank(int a, int v);
        we = 1'b1; waddr = AW'(a); wdata = WI'(v);
        @(negedge clk);
        we = 1'b0;
        bank_m[a*WI +: WI] = WI'(v);
    endtask

    task automatic run(string tag);
        logic [OUT_W-1:0] exp_d = ref_out();
        bit oor = any_oor();
        bit exp_w = oor && (pol == 2'd1);
        if (oor && pol == 2'd2) err_exp = 1'b1;
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        for (int i = 1; i < LAT; i++) begin
            chk(vld_o == 1'b0, {tag, " R10 early valid"}, OUT_W'(vld_o), '0);
            @(negedge clk);
        end
        chk(vld_o == 1'b1, {tag, " R10 valid at latency"}, OUT_W'(vld_o), OUT_W'(1));
        chk(dat_o == exp_d, {tag, " data"}, dat_o, exp_d);
        chk(warn_o == exp_w, {tag, " R7 warn"}, OUT_W'(warn_o), OUT_W'(exp_w));
        chk(err_o == err_exp, {tag, " R7 err"}, OUT_W'(err_o), OUT_W'(err_exp));
        @(negedge clk);
        chk(vld_o == 1'b0, {tag, " R10 single beat"}, OUT_W'(vld_o), '0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(vld_o == 1'b0 && warn_o == 1'b0 && err_o == 1'b0, "R11 reset outputs",
            OUT_W'({vld_o, warn_o, err_o}), '0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R3: row mode, one-based, repeated row and an unused row
        rand_mat(); cols = 0; zb = 0; put_idx(2, 2, 1); run("R1 R3 rows repeat");
        put_idx(4, 3, 1); run("R1 rows distinct");
        // R2: column mode
        cols = 1; put_idx(5, 1, 3); run("R2 cols");
        put_idx(1, 1, 1); run("R2 R3 cols same");
        // R4: zero base
        zb = 1; put_idx(0, 4, 2); run("R4 zero base cols");
        cols = 0; put_idx(3, 0, 0); run("R4 zero base rows");
        // R5 R6: clamping, silent policy
        zb = 0; pol = 0; put_idx(30, -2, 4); run("R5 R6 rows clamp silent");
        cols = 1; put_idx(30, -2, 0); run("R5 R6 cols clamp silent");
        zb = 1; put_idx(-1, 5, 4); run("R5 R6 zero base clamp");
        // R7: warn policy, then in range with warn policy
        pol = 1; put_idx(-1, 1, 9); run("R7 warn policy clamp");
        put_idx(0, 1, 2); run("R7 warn policy in range");
        pol = 3; put_idx(-5, 0, 0); run("R7 reserved acts silent");
        // R8: logical mode
        lg = 1; pol = 1; fill = 8'hA5;
        cols = 1; mask = 5'b10110; run("R8 cols mask");
        cols = 0; mask = 5'b10101; run("R8 rows mask high bit ignored");
        mask = 5'b00000; run("R8 empty mask all fill");
        cols = 1; mask = 5'b11111; run("R8 full mask identity");
        lg = 0;
        // R9: index bank
        src = 1; zb = 0; cols = 0; put_idx(1, 1, 1);
        wr_bank(0, 4); wr_bank(1, 2); wr_bank(2, 3);
        run("R9 bank rows");
        wr_bank(1, 7); cols = 1; run("R9 bank rewrite clamp");
        src = 0;
        // R7: error policy, sticky
        pol = 2; cols = 0; put_idx(1, 9, 2); run("R7 error policy hit");
        put_idx(1, 2, 3); run("R7 error sticky");

        for (int t = 0; t < 300; t++) begin
            rand_mat();
            cols = 1'($urandom); zb = 1'($urandom); lg = 1'($urandom_range(0, 3) == 0);
            pol = 2'($urandom); src = 1'($urandom_range(0, 4) == 0);
            mask = MAXD'($urandom); fill = W'($urandom);
            for (int k = 0; k < L; k++) idx[k*WI +: WI] = WI'(int'($urandom_range(0, 11)) - 3);
            if (src && $urandom_range(0, 1) == 1) wr_bank($urandom_range(0, L-1), int'($urandom_range(0, 9)) - 2);
            run("R1 R2 R3 random");
        end

        // R11: reset clears the sticky error and the bank
        rst = 1'b1; @(negedge clk); rst = 1'b0; err_exp = 1'b0; bank_m = '0;
        chk(err_o == 1'b0, "R11 err cleared", OUT_W'(err_o), '0);
        src = 1; lg = 0; zb = 1; pol = 0; cols = 0; run("R11 R9 bank zero after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule